// File: doc/BRIEF.md
# Write-Burst to Stream Packer

This block is a memory-mapped write target that turns the data of incoming write bursts into a 32-bit stream. It takes bursts on the AW and W channels and answers each one on the B channel. Every accepted data word of a data burst leaves as exactly one stream beat, in the order it was written.

The bursts carry no length for the whole packet, so packet boundaries come from addresses. A burst that starts at address zero begins a new packet, and a single-word write to the command address (default 0x1000) closes the packet in progress. Whether a word ends a packet is only known once the next write arrives. The block therefore always keeps the newest data word in a hold register. It releases that word into a small output FIFO, with or without the end-of-packet flag, when the next data word or a command write comes in.

Only one address phase is in flight at a time. The write response is issued once the final data word of the burst has been accepted. Back-pressure on the stream fills the FIFO first, and then stops write data from being accepted.

Top module: `wrburst_packer`

## Requirements
- R1: Each W beat accepted in a data burst yields exactly one stream beat carrying the same 32-bit word. Stream beats keep the order in which the words were written.
- R2: The newest accepted data word is always held back. A lone 4-beat burst followed by idle cycles puts exactly 3 beats on the stream, none of them with tLast.
- R3: When the first W beat of a burst that starts at address 0 is accepted while a word is held, the held word is released with tLast = 1.
- R4: When a W beat of a burst with a nonzero start address (for example 0x0020) is accepted, the held word is released with tLast = 0.
- R5: A write with awLen = 0 to the command address (0x1000) is not forwarded as data. Its W beat releases the held word with tLast = 1.
- R6: A command write that arrives while no word is held produces no stream beat.
- R7: bResp is 0 (OKAY) and bId equals the awId of the burst. bValid and bId stay unchanged while bReady is low.
- R8: While tValid is high and tReady is low, tData and tLast stay unchanged. wReady is low in a data or command phase exactly when a word is held and the FIFO holds FIFO_DEPTH (default 4) entries, so no word is lost.
- R9: awReady is high only when no burst is in progress. wReady is never high at the same time as awReady. bValid rises only in the cycle after a W beat with wLast = 1 has been accepted.
- R10: aresetN is active low and synchronous. Reset empties the FIFO, drops the held word and returns to the idle state, so a command write right after reset produces no beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| aclk | input | 1 | Clock |
| aresetN | input | 1 | Synchronous reset, active low |
| awId | input | ID_W | Burst ID |
| awAddr | input | ADDR_W | Burst start address |
| awLen | input | LEN_W | Beats minus one |
| awValid | input | 1 | Address valid |
| awReady | output | 1 | Address accepted |
| wData | input | DATA_W | Write word |
| wLast | input | 1 | Final beat of the burst |
| wValid | input | 1 | Write word valid |
| wReady | output | 1 | Write word accepted |
| bId | output | ID_W | Response ID |
| bResp | output | 2 | Response code, always OKAY |
| bValid | output | 1 | Response valid |
| bReady | input | 1 | Response taken |
| tData | output | DATA_W | Stream word |
| tLast | output | 1 | End of packet |
| tValid | output | 1 | Stream word valid |
| tReady | input | 1 | Stream sink ready |

## Verification
A lone address-zero burst with no later activity shows that the newest word is withheld. A second address-zero burst, run under a long stream stall, shows that the held word closes the packet and that wReady drops once the hold register and FIFO are full. Back-to-back bursts at 0x0000 and 0x0020, with a late bReady and a stall in the middle of a burst, separate a continuing packet from a new one. Two command writes in a row separate the closing command from an empty one, and a reset taken while a word is held shows that the word is dropped.

// File: rtl/wrpack_pkg.sv
package wrpack_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_DATA = 2'd1,
    PH_CMD  = 2'd2,
    PH_RESP = 2'd3
  } phase_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic loadHold;   // capture the incoming word into the hold register
    logic pushHold;   // move the held word into the output FIFO
    logic pushLast;   // end-of-packet flag for the pushed word
    logic dropHold;   // hold register becomes empty
  } dpCtrl_t;

endpackage

// File: rtl/wrpack_fifo.sv
module wrpack_fifo #(
  parameter int W     = 33,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         push,
  input  logic [W-1:0] pushData,
  input  logic         pop,
  output logic [W-1:0] popData,
  output logic         notEmpty,
  output logic         full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;
  logic [CNT_W-1:0] count;

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= (wrPtr == LAST_SLOT) ? '0 : wrPtr + 1'b1;
      if (pop)  rdPtr <= (rdPtr == LAST_SLOT) ? '0 : rdPtr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign popData  = mem[rdPtr];
  assign notEmpty = (count != '0);
  assign full     = (count == CNT_W'(DEPTH));
endmodule

// File: rtl/wrpack_dp.sv
module wrpack_dp
  import wrpack_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           ctl,
  input  logic [DATA_W-1:0] wData,
  input  logic              tReady,
  output logic              holdValid,
  output logic              fifoFull,
  output logic [DATA_W-1:0] tData,
  output logic              tLast,
  output logic              tValid
);
  localparam int ENTRY_W = DATA_W + 1;

  logic [DATA_W-1:0]  holdData;
  logic [ENTRY_W-1:0] headEntry;
  logic               popEn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdValid <= 1'b0;
      holdData  <= '0;
    end else if (ctl.loadHold) begin
      holdValid <= 1'b1;
      holdData  <= wData;
    end else if (ctl.dropHold) begin
      holdValid <= 1'b0;
    end
  end

  assign popEn = tValid && tReady;

  wrpack_fifo #(
    .W     (ENTRY_W),
    .DEPTH (DEPTH)
  ) uFifo (
    .clk      (clk),
    .rstN     (rstN),
    .push     (ctl.pushHold),
    .pushData ({ctl.pushLast, holdData}),
    .pop      (popEn),
    .popData  (headEntry),
    .notEmpty (tValid),
    .full     (fifoFull)
  );

  assign tData = headEntry[DATA_W-1:0];
  assign tLast = headEntry[DATA_W];
endmodule

// File: rtl/wrpack_ctrl.sv
module wrpack_ctrl
  import wrpack_pkg::*;
#(
  parameter int              ID_W     = 4,
  parameter int              ADDR_W   = 16,
  parameter int              LEN_W    = 8,
  parameter logic [ADDR_W-1:0] CMD_ADDR = 16'h1000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ID_W-1:0]   awId,
  input  logic [ADDR_W-1:0] awAddr,
  input  logic [LEN_W-1:0]  awLen,
  input  logic              awValid,
  output logic              awReady,
  input  logic              wLast,
  input  logic              wValid,
  output logic              wReady,
  output logic [ID_W-1:0]   bId,
  output logic              bValid,
  input  logic              bReady,
  input  logic              holdValid,
  input  logic              fifoFull,
  output dpCtrl_t           ctl
);
  phase_t          phase;
  logic [ID_W-1:0] idReg;
  logic            openPkt;
  logic            firstBeat;
  logic            isCmd;
  logic            canTake;
  logic            wFire;

  assign isCmd   = (awAddr == CMD_ADDR) && (awLen == '0);
  assign canTake = !holdValid || !fifoFull;
  assign awReady = (phase == PH_IDLE);
  assign wReady  = ((phase == PH_DATA) || (phase == PH_CMD)) && canTake;
  assign wFire   = wValid && wReady;
  assign bValid  = (phase == PH_RESP);
  assign bId     = idReg;

  always_comb begin
    ctl          = '0;
    ctl.loadHold = wFire && (phase == PH_DATA);
    ctl.pushHold = wFire && holdValid;
    ctl.pushLast = (phase == PH_CMD) || (firstBeat && openPkt);
    ctl.dropHold = wFire && (phase == PH_CMD);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase     <= PH_IDLE;
      idReg     <= '0;
      openPkt   <= 1'b0;
      firstBeat <= 1'b0;
    end else begin
      case (phase)
        PH_IDLE: if (awValid) begin
          idReg     <= awId;
          openPkt   <= (awAddr == '0);
          firstBeat <= 1'b1;
          phase     <= isCmd ? PH_CMD : PH_DATA;
        end
        PH_DATA: if (wFire) begin
          firstBeat <= 1'b0;
          if (wLast) phase <= PH_RESP;
        end
        PH_CMD: if (wFire) begin
          firstBeat <= 1'b0;
          phase     <= PH_RESP;
        end
        PH_RESP: if (bReady) phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wrburst_packer.sv
module wrburst_packer
  import wrpack_pkg::*;
#(
  parameter int              ID_W       = 4,
  parameter int              ADDR_W     = 16,
  parameter int              LEN_W      = 8,
  parameter int              DATA_W     = 32,
  parameter int              FIFO_DEPTH = 4,
  parameter logic [ADDR_W-1:0] CMD_ADDR   = 16'h1000
) (
  input  logic              aclk,
  input  logic              aresetN,
  input  logic [ID_W-1:0]   awId,
  input  logic [ADDR_W-1:0] awAddr,
  input  logic [LEN_W-1:0]  awLen,
  input  logic              awValid,
  output logic              awReady,
  input  logic [DATA_W-1:0] wData,
  input  logic              wLast,
  input  logic              wValid,
  output logic              wReady,
  output logic [ID_W-1:0]   bId,
  output logic [1:0]        bResp,
  output logic              bValid,
  input  logic              bReady,
  output logic [DATA_W-1:0] tData,
  output logic              tLast,
  output logic              tValid,
  input  logic              tReady
);
  dpCtrl_t ctl;
  logic    holdValid;
  logic    fifoFull;

  assign bResp = 2'b00;

  wrpack_ctrl #(
    .ID_W     (ID_W),
    .ADDR_W   (ADDR_W),
    .LEN_W    (LEN_W),
    .CMD_ADDR (CMD_ADDR)
  ) uCtrl (
    .clk       (aclk),
    .rstN      (aresetN),
    .awId      (awId),
    .awAddr    (awAddr),
    .awLen     (awLen),
    .awValid   (awValid),
    .awReady   (awReady),
    .wLast     (wLast),
    .wValid    (wValid),
    .wReady    (wReady),
    .bId       (bId),
    .bValid    (bValid),
    .bReady    (bReady),
    .holdValid (holdValid),
    .fifoFull  (fifoFull),
    .ctl       (ctl)
  );

  wrpack_dp #(
    .DATA_W (DATA_W),
    .DEPTH  (FIFO_DEPTH)
  ) uDp (
    .clk       (aclk),
    .rstN      (aresetN),
    .ctl       (ctl),
    .wData     (wData),
    .tReady    (tReady),
    .holdValid (holdValid),
    .fifoFull  (fifoFull),
    .tData     (tData),
    .tLast     (tLast),
    .tValid    (tValid)
  );
endmodule

// File: rtl/wrpack_chk.sv
module wrpack_chk #(
  parameter int ID_W   = 4,
  parameter int DATA_W = 32
) (
  input logic              aclk,
  input logic              aresetN,
  input logic              awReady,
  input logic              wValid,
  input logic              wReady,
  input logic              wLast,
  input logic              bValid,
  input logic              bReady,
  input logic [ID_W-1:0]   bId,
  input logic              tValid,
  input logic              tReady,
  input logic [DATA_W-1:0] tData,
  input logic              tLast
);
  AST_B_HELD: assert property (@(posedge aclk) disable iff (!aresetN)
    bValid && !bReady |=> bValid && $stable(bId));  // R7

  AST_STREAM_HELD: assert property (@(posedge aclk) disable iff (!aresetN)
    tValid && !tReady |=> tValid && $stable(tData) && $stable(tLast));  // R8

  AST_ONE_BURST: assert property (@(posedge aclk) disable iff (!aresetN)
    awReady |-> !wReady && !bValid);  // R9

  AST_B_AFTER_LAST: assert property (@(posedge aclk) disable iff (!aresetN)
    $rose(bValid) |-> $past(wValid && wReady && wLast));  // R9

  AST_RESET_CLEARS: assert property (@(posedge aclk)
    !aresetN |=> !tValid && !bValid);  // R10
endmodule

bind wrburst_packer wrpack_chk #(
  .ID_W   (ID_W),
  .DATA_W (DATA_W)
) uChk (
  .aclk    (aclk),
  .aresetN (aresetN),
  .awReady (awReady),
  .wValid  (wValid),
  .wReady  (wReady),
  .wLast   (wLast),
  .bValid  (bValid),
  .bReady  (bReady),
  .bId     (bId),
  .tValid  (tValid),
  .tReady  (tReady),
  .tData   (tData),
  .tLast   (tLast)
);

// File: tb/wrburst_packer_test.sv
module wrburst_packer_test;
  localparam int DEPTH = 4;
  localparam logic [15:0] CMD = 16'h1000;

  logic        aclk = 1'b0;
  logic        aresetN = 1'b0;
  logic [3:0]  awId = '0;
  logic [15:0] awAddr = '0;
  logic [7:0]  awLen = '0;
  logic        awValid = 1'b0;
  logic        awReady;
  logic [31:0] wData = '0;
  logic        wLast = 1'b0;
  logic        wValid = 1'b0;
  logic        wReady;
  logic [3:0]  bId;
  logic [1:0]  bResp;
  logic        bValid;
  logic        bReady = 1'b0;
  logic [31:0] tData;
  logic        tLast;
  logic        tValid;
  logic        tReady = 1'b1;

  wrburst_packer uut (
    .aclk(aclk), .aresetN(aresetN), .awId(awId), .awAddr(awAddr), .awLen(awLen),
    .awValid(awValid), .awReady(awReady), .wData(wData), .wLast(wLast),
    .wValid(wValid), .wReady(wReady), .bId(bId), .bResp(bResp), .bValid(bValid),
    .bReady(bReady), .tData(tData), .tLast(tLast), .tValid(tValid), .tReady(tReady)
  );

  always #2 aclk = ~aclk;  // 250 MHz

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int beats = 0;
  int lasts = 0;
  int stallFrom = 0;
  int stallTo = 0;
  bit sawWLow = 0;
  logic [31:0] nextVal = 32'd1;

  // behavioural reference model
  logic [32:0] q[$];
  bit          mHold = 0;
  logic [31:0] mHoldD = '0;
  int          mPh = 0;     // 0 idle, 1 data, 2 command, 3 response
  logic [3:0]  mBid = '0;
  bit          mOpen = 0;
  bit          mFirst = 0;

  function automatic bit mWRdy();
    return (mPh == 1 || mPh == 2) && (!mHold || q.size() < DEPTH);
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s cycle %0d actual=%0h expected=%0h", req, cyc, act, exp);
    end
  endtask

  always @(posedge aclk) begin
    cyc++;
    if (!aresetN) begin
      q.delete(); mHold = 0; mPh = 0; mOpen = 0; mFirst = 0;
    end else begin
      bit wF, tF;
      wF = mWRdy() && wValid;
      tF = (q.size() > 0) && tReady;
      if (tF) void'(q.pop_front());
      if (wF && mHold) q.push_back({(mPh == 2) || (mFirst && mOpen), mHoldD});
      if (wF) begin
        mFirst = 0;
        if (mPh == 1) begin mHold = 1; mHoldD = wData; end
        else mHold = 0;
      end
      case (mPh)
        0: if (awValid) begin
          mBid = awId; mOpen = (awAddr == 16'h0); mFirst = 1;
          mPh = (awAddr == CMD && awLen == 8'd0) ? 2 : 1;
        end
        1: if (wF && wLast) mPh = 3;
        2: if (wF) mPh = 3;
        3: if (bReady) mPh = 0;
        default: mPh = 0;
      endcase
    end
  end

  // compare every cycle, then drive tReady and count stream beats
  always @(negedge aclk) begin
    if (cyc >= 2) begin
      check(tValid == (q.size() != 0), "R1 tValid", 64'(tValid), 64'(q.size() != 0));
      if (q.size() != 0 && tValid) begin
        check(tData == q[0][31:0], "R1 tData", 64'(tData), 64'(q[0][31:0]));
        check(tLast == q[0][32], "R3/R4/R5 tLast", 64'(tLast), 64'(q[0][32]));
      end
      check(wReady == mWRdy(), "R8 wReady", 64'(wReady), 64'(mWRdy()));
      check(awReady == (mPh == 0), "R9 awReady", 64'(awReady), 64'(mPh == 0));
      check(bValid == (mPh == 3), "R7 bValid", 64'(bValid), 64'(mPh == 3));
      if (mPh == 3) begin
        check(bId == mBid, "R7 bId", 64'(bId), 64'(mBid));
        check(bResp == 2'b00, "R7 bResp", 64'(bResp), 64'd0);
      end
      if ((mPh == 1 || mPh == 2) && !wReady) sawWLow = 1;
    end
    tReady = !(cyc >= stallFrom && cyc < stallTo);
    if (tValid && tReady && aresetN) begin
      beats++;
      if (tLast) lasts++;
    end
  end

  task automatic burst(input logic [15:0] addr, input int n, input logic [3:0] id, input int bDelay);
    awAddr = addr; awLen = 8'(n - 1); awId = id; awValid = 1'b1;
    while (!awReady) @(negedge aclk);
    @(negedge aclk);
    awValid = 1'b0;
    for (int i = 0; i < n; i++) begin
      wData = (addr == CMD && n == 1) ? 32'd1 : nextVal;
      if (!(addr == CMD && n == 1)) nextVal++;
      wLast = (i == n - 1);
      wValid = 1'b1;
      while (!wReady) @(negedge aclk);
      @(negedge aclk);
    end
    wValid = 1'b0; wLast = 1'b0;
    repeat (bDelay) @(negedge aclk);
    bReady = 1'b1;
    while (!bValid) @(negedge aclk);
    @(negedge aclk);
    bReady = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge aclk);
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge aclk);
    checks++; failures++;
    $display("FAIL R9 watchdog actual=hung expected=complete");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge aclk);
    aresetN = 1'b1;
    @(negedge aclk);
    // R10 reset state
    check(!tValid && awReady && !bValid, "R10 reset state", {tValid, awReady, bValid}, 3'b010);

    // R2: lone 4-beat burst leaves one word held
    burst(16'h0000, 4, 4'd1, 0);
    idle(12);
    check(beats == 3, "R2 beat count", beats, 3);
    check(lasts == 0, "R2 tLast count", lasts, 0);

    // R3 + R8: new packet at address 0 under a long stall
    stallFrom = cyc; stallTo = cyc + 30;
    burst(16'h0000, 8, 4'd0, 0);
    idle(40);
    check(sawWLow, "R8 wReady dropped when full", 64'(sawWLow), 1);
    check(beats == 11, "R1/R3 beat count", beats, 11);
    check(lasts == 1, "R3 tLast count", lasts, 1);

    // R5, R6: two command writes
    burst(CMD, 1, 4'd2, 0);
    idle(8);
    check(beats == 12, "R5 beat count", beats, 12);
    check(lasts == 2, "R5 tLast count", lasts, 2);
    burst(CMD, 1, 4'd3, 0);
    idle(8);
    check(beats == 12 && lasts == 2, "R6 no extra beat", {32'(beats), 32'(lasts)}, {32'd12, 32'd2});

    // R10: reset while a word is held, then command
    burst(16'h0040, 2, 4'd4, 0);
    idle(6);
    aresetN = 1'b0;
    idle(2);
    aresetN = 1'b1;
    @(negedge aclk);
    beats = 0; lasts = 0;
    burst(CMD, 1, 4'd5, 0);
    idle(8);
    check(beats == 0, "R10 held word dropped", beats, 0);

    // R4 + R7: continued packet, late bReady, stall in mid burst
    beats = 0; lasts = 0;
    burst(16'h0000, 16, 4'd6, 5);
    stallFrom = cyc + 3; stallTo = cyc + 19;
    burst(16'h0020, 16, 4'd7, 5);
    burst(CMD, 1, 4'd8, 0);
    burst(CMD, 1, 4'd9, 0);
    idle(40);
    check(beats == 32, "R4 beat count", beats, 32);
    check(lasts == 1, "R4 tLast count", lasts, 1);

    finishRun();
  end
endmodule